// File: doc/BRIEF.md
# Light-Level Window Interrupt with Persistence

The block takes a stream of 16-bit light conversion results. A one-cycle strobe marks each result at the end of an integration period. Each result is compared with a programmable low bound and a programmable high bound. When enough consecutive results lie outside that window, the block raises an active-low interrupt. The required run length is selectable as 1, 4, 8 or 16 results. At the same moment it sets a sticky status flag in its control byte.

Software programs the bounds and the run length through a small byte-wide register interface. It finds the interrupt by reading the control byte. When the bus logic finishes a read of the control byte, it pulses a strobe, and that strobe clears both the flag and the interrupt. The serial bus, the converter and the sequencing of operating modes sit outside this block.

Top module: `als_win_irq`

## Requirements
- R1: After reset the control byte reads 0x00, the low bound reads 0x0000, the high bound reads 0xFFFF and `irq_n` is high.
- R2: Register map:
  - the low bound is at address 0x4 (bits 7:0) and 0x5 (bits 15:8);
  - the high bound is at 0x6 (bits 7:0) and 0x7 (bits 15:8);
  - the control byte is at 0x0, with bits 7:5 a stored mode field, bits 4:3 reading 0, bit 2 the status flag and bits 1:0 the run-length field;
  - every other address reads 0x00.
- R3: The status bit (control bit 2) cannot be written; a control write leaves it unchanged.
- R4: A result is outside the window only if it is strictly less than the low bound or strictly greater than the high bound. A result equal to either bound is inside.
- R5: The run-length field encodes 00 = 1, 01 = 4, 10 = 8 and 11 = 16 consecutive outside results. The flag sets, and `irq_n` falls, on the result that completes the run.
- R6: Any in-window result restarts the run count. Cycles without `res_vld` leave it unchanged, whatever the value on `res_data`.
- R7: The run count saturates at 16 and does not wrap. If the flag is cleared while the count is saturated, the next outside result sets it again.
- R8: Once set, the flag and the low `irq_n` persist through in-window results until a clear.
- R9: A pulse on `ctrl_rd_done` clears the flag, and `irq_n` returns high on the following cycle.
- R10: If `ctrl_rd_done` and a result that completes a run arrive in the same cycle, the flag stays set.
- R11: A control write that changes the run-length field restarts the run count, so the new length counts from the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| ctrl_rd_done | input | 1 | Pulse marking the end of a control-byte read |
| res_data | input | 16 | Conversion result |
| res_vld | input | 1 | One-cycle strobe marking `res_data` as a new result |
| irq_n | output | 1 | Active-low sticky interrupt |

## Verification
Two situations are hard to reach from the ports.

The first is a clear strobe landing in exactly the cycle in which a result completes a run. The bench drives `ctrl_rd_done` and the completing result on the same falling edge, with the run length at 1, so the collision is certain.

The second is saturation, and how it behaves after a clear. The bench pushes twenty outside results at run length 16, clears the flag, and shows that a single further outside result sets it again.

A run-length change in the middle of a run is forced the same way. The bench writes a shorter length partway through a run and checks that the full new length is still needed.

// File: rtl/als_win_pkg.sv
package als_win_pkg;
    localparam int RES_W  = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;
    localparam int RUN_MAX = 16;
    localparam int CNT_W  = $clog2(RUN_MAX + 1);

    typedef enum logic [1:0] {
        PERS_1  = 2'b00,
        PERS_4  = 2'b01,
        PERS_8  = 2'b10,
        PERS_16 = 2'b11
    } persist_e;

    typedef struct packed {
        logic [2:0] mode;
        persist_e   persist;
    } ctrl_t;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] A_LO_L = 4'h4;
    localparam logic [ADDR_W-1:0] A_LO_H = 4'h5;
    localparam logic [ADDR_W-1:0] A_HI_L = 4'h6;
    localparam logic [ADDR_W-1:0] A_HI_H = 4'h7;

    function automatic logic [CNT_W-1:0] run_len(persist_e p);
        case (p)
            PERS_1:  run_len = CNT_W'(1);
            PERS_4:  run_len = CNT_W'(4);
            PERS_8:  run_len = CNT_W'(8);
            default: run_len = CNT_W'(RUN_MAX);
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] pack_ctrl(ctrl_t c, logic status);
        pack_ctrl = {c.mode, 2'b00, status, c.persist};
    endfunction
endpackage

// File: rtl/als_win_regs.sv
module als_win_regs
    import als_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              status,
    output logic [BYTE_W-1:0] rd_data,
    output ctrl_t             ctrl,
    output logic [RES_W-1:0]  thr_lo,
    output logic [RES_W-1:0]  thr_hi,
    output logic              persist_chg
);
    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data[4:2];

    logic ctrl_wr;
    assign ctrl_wr     = wr_en && (wr_addr == A_CTRL);
    assign persist_chg = ctrl_wr && (persist_e'(wr_data[1:0]) != ctrl.persist);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '{mode: 3'b000, persist: PERS_1};
            thr_lo <= '0;
            thr_hi <= '1;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: ctrl <= '{mode: wr_data[7:5], persist: persist_e'(wr_data[1:0])};
                A_LO_L: thr_lo[7:0]  <= wr_data;
                A_LO_H: thr_lo[15:8] <= wr_data;
                A_HI_L: thr_hi[7:0]  <= wr_data;
                A_HI_H: thr_hi[15:8] <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_addr)
            A_CTRL:  rd_data = pack_ctrl(ctrl, status);
            A_LO_L:  rd_data = thr_lo[7:0];
            A_LO_H:  rd_data = thr_lo[15:8];
            A_HI_L:  rd_data = thr_hi[7:0];
            A_HI_H:  rd_data = thr_hi[15:8];
            default: rd_data = '0;
        endcase
    end

    // R2
    lo_lsb_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_LO_L) |=> (thr_lo[7:0] == $past(wr_data)));

    // R2
    hi_msb_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_HI_H) |=> (thr_hi[15:8] == $past(wr_data)));
endmodule

// File: rtl/als_win_cmp.sv
module als_win_cmp #(
    parameter int W = 16
) (
    input  logic [W-1:0] sample,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         outside
);
    logic below, above;
    assign below   = sample < lo;
    assign above   = sample > hi;
    assign outside = below || above;

    // R4
    equal_bound_inside_chk: assert final ((sample != lo && sample != hi) || lo > hi || !outside);
endmodule

// File: rtl/als_win_persist.sv
module als_win_persist
    import als_win_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sample_vld,
    input  logic     outside,
    input  persist_e persist,
    input  logic     persist_chg,
    input  logic     clr,
    output logic     flag
);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(RUN_MAX);

    logic [CNT_W-1:0] cnt, cnt_inc;
    logic             trig;

    assign cnt_inc = (cnt == CNT_SAT) ? CNT_SAT : cnt + 1'b1;
    assign trig    = sample_vld && outside && !persist_chg && (cnt_inc >= run_len(persist));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (persist_chg) begin
            cnt <= '0;
        end else if (sample_vld) begin
            cnt <= outside ? cnt_inc : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       flag <= 1'b0;
        else if (trig) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt <= CNT_SAT);

    // R6
    inwin_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_vld && !outside) |=> (cnt == '0));

    // R11
    persist_chg_restart_chk: assert property (@(posedge clk) disable iff (rst)
        persist_chg |=> (cnt == '0));

    // R5
    flag_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> ($past(sample_vld) && $past(outside)));

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !(sample_vld && outside)) |=> !flag);

    // R10
    trig_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && trig) |=> flag);
endmodule

// File: rtl/als_win_irq.sv
module als_win_irq
    import als_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              ctrl_rd_done,
    input  logic [RES_W-1:0]  res_data,
    input  logic              res_vld,
    output logic              irq_n
);
    ctrl_t            ctrl;
    logic [RES_W-1:0] thr_lo, thr_hi;
    logic             persist_chg, outside, flag;

    als_win_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .status(flag), .rd_data(rd_data), .ctrl(ctrl),
        .thr_lo(thr_lo), .thr_hi(thr_hi), .persist_chg(persist_chg)
    );

    als_win_cmp #(.W(RES_W)) u_cmp (
        .sample(res_data), .lo(thr_lo), .hi(thr_hi), .outside(outside)
    );

    als_win_persist u_persist (
        .clk(clk), .rst(rst), .sample_vld(res_vld), .outside(outside),
        .persist(ctrl.persist), .persist_chg(persist_chg), .clr(ctrl_rd_done),
        .flag(flag)
    );

    assign irq_n = ~flag;

    // R3
    status_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_CTRL && !res_vld && !ctrl_rd_done) |=> $stable(flag));

    // R1
    reset_irq_chk: assert property (@(posedge clk) $past(rst) |-> irq_n);
endmodule

// File: tb/als_win_irq_tb.sv
`timescale 1ns/1ps
module als_win_irq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ctrl_rd_done = 1'b0;
    logic [15:0] res_data = '0;
    logic       res_vld = 1'b0;
    logic       irq_n;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    als_win_irq dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ctrl_rd_done(ctrl_rd_done),
        .res_data(res_data), .res_vld(res_vld), .irq_n(irq_n)
    );

    localparam logic [15:0] LO = 16'h1000;
    localparam logic [15:0] HI = 16'h2000;
    localparam logic [15:0] OUT_V = 16'h3000;
    localparam logic [15:0] IN_V  = 16'h1800;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        rd_addr = a; #0.5; d = rd_data;
    endtask

    task automatic send(logic [15:0] v);
        @(negedge clk); res_data = v; res_vld = 1'b1;
        @(negedge clk); res_vld = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk); ctrl_rd_done = 1'b1;
        @(negedge clk); ctrl_rd_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 irq_n", irq_n, 1);
        rd(4'h0, d); chk("R1 ctrl", d, 8'h00);
        rd(4'h4, d); chk("R1 lo_l", d, 8'h00);
        rd(4'h5, d); chk("R1 lo_h", d, 8'h00);
        rd(4'h6, d); chk("R1 hi_l", d, 8'hFF);
        rd(4'h7, d); chk("R1 hi_h", d, 8'hFF);
        rd(4'h3, d); chk("R2 unmapped", d, 8'h00);
    endtask

    task automatic t_regmap();
        logic [7:0] d;
        wr(4'h4, 8'h34); wr(4'h5, 8'h12); wr(4'h6, 8'h78); wr(4'h7, 8'h56);
        rd(4'h4, d); chk("R2 lo_l", d, 8'h34);
        rd(4'h5, d); chk("R2 lo_h", d, 8'h12);
        rd(4'h6, d); chk("R2 hi_l", d, 8'h78);
        rd(4'h7, d); chk("R2 hi_h", d, 8'h56);
        wr(4'h0, 8'hFF);
        rd(4'h0, d); chk("R2 R3 ctrl layout", d, 8'hE3);
        wr(4'h0, 8'h00);
        wr(4'h4, LO[7:0]); wr(4'h5, LO[15:8]); wr(4'h6, HI[7:0]); wr(4'h7, HI[15:8]);
    endtask

    task automatic t_window();
        logic [7:0] d;
        send(LO);   chk("R4 equal low", irq_n, 1);
        send(HI);   chk("R4 equal high", irq_n, 1);
        send(IN_V); chk("R4 inside", irq_n, 1);
        @(negedge clk); res_data = 16'h0001; repeat (3) @(negedge clk);
        chk("R6 no strobe", irq_n, 1);
        send(LO - 16'd1); chk("R4 below", irq_n, 0);
        rd(4'h0, d); chk("R5 status set", d, 8'h04);
        clear_irq(); chk("R9 cleared", irq_n, 1);
        rd(4'h0, d); chk("R9 status clear", d, 8'h00);
        send(HI + 16'd1); chk("R4 above", irq_n, 0);
        clear_irq(); send(IN_V);
    endtask

    task automatic t_persist();
        int lens[4] = '{1, 4, 8, 16};
        for (int p = 1; p < 4; p++) begin
            wr(4'h0, 8'(p));
            for (int i = 0; i < lens[p] - 1; i++) send(OUT_V);
            chk($sformatf("R5 p=%0d short run", p), irq_n, 1);
            send(OUT_V);
            chk($sformatf("R5 p=%0d full run", p), irq_n, 0);
            clear_irq(); send(IN_V);
        end
    endtask

    task automatic t_run_restart();
        wr(4'h0, 8'h01);
        repeat (3) send(OUT_V);
        send(IN_V);
        repeat (3) send(OUT_V);
        @(negedge clk); res_data = OUT_V; repeat (2) @(negedge clk);
        chk("R6 restart", irq_n, 1);
        send(OUT_V); chk("R6 after restart", irq_n, 0);
        clear_irq(); send(IN_V);
    endtask

    task automatic t_saturate();
        logic [7:0] d;
        wr(4'h0, 8'h03);
        repeat (20) send(OUT_V);
        chk("R7 long run", irq_n, 0);
        repeat (3) send(IN_V);
        chk("R8 sticky irq", irq_n, 0);
        rd(4'h0, d); chk("R8 sticky status", d, 8'h07);
        clear_irq(); chk("R9 clear", irq_n, 1);
        repeat (20) send(OUT_V);
        clear_irq(); chk("R9 clear sat", irq_n, 1);
        send(OUT_V); chk("R7 resat", irq_n, 0);
        clear_irq(); send(IN_V);
    endtask

    task automatic t_collide();
        wr(4'h0, 8'h00);
        @(negedge clk); res_data = OUT_V; res_vld = 1'b1; ctrl_rd_done = 1'b1;
        @(negedge clk); res_vld = 1'b0; ctrl_rd_done = 1'b0;
        chk("R10 trigger wins", irq_n, 0);
        @(negedge clk); res_data = IN_V; res_vld = 1'b1; ctrl_rd_done = 1'b1;
        @(negedge clk); res_vld = 1'b0; ctrl_rd_done = 1'b0;
        chk("R9 clear with inside", irq_n, 1);
    endtask

    task automatic t_status_ro();
        logic [7:0] d;
        wr(4'h0, 8'h04);
        rd(4'h0, d); chk("R3 write one", d, 8'h00);
        send(OUT_V);
        wr(4'h0, 8'h00);
        rd(4'h0, d); chk("R3 write zero", d, 8'h04);
        chk("R3 irq kept", irq_n, 0);
        clear_irq(); send(IN_V);
    endtask

    task automatic t_persist_change();
        wr(4'h0, 8'h02);
        repeat (5) send(OUT_V);
        wr(4'h0, 8'h01);
        repeat (3) send(OUT_V);
        chk("R11 restarted", irq_n, 1);
        send(OUT_V);
        chk("R11 new length", irq_n, 0);
        clear_irq();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_window();
        t_persist();
        t_run_restart();
        t_saturate();
        t_collide();
        t_status_ro();
        t_persist_change();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule